// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits at the decode stage of a single-issue pipeline whose floating-point operations run on units with very different result latencies and repeat rates. Each cycle it looks at one decoded operation: its class, whether it writes a register, its destination and up to two sources. It answers with a single decision, issue or hold. A held operation stays at decode, so everything younger waits behind it and issue order never changes. Completion order can still differ from program order, because a short operation issued after a long one can finish first.

Three kinds of state back the decision. Each register has a countdown of cycles until its pending result lands. Each class has a countdown until it may accept another operation. A reservation line holds one bit for each future cycle and records when the single write-back port is already taken. A synchronous flush clears all three.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset, and with `dec_valid` low, `issue`, `stall` and `wb_valid` are all 0. The first operation after reset issues in the cycle it is presented.
- R2: The class code on `dec_op` selects the result latency L: 0 add/subtract L=4, 1 multiply L=8, 2 divide L=36, 3 square root L=112, 4 negate L=2, 5 absolute value L=2, 6 compare L=3, and 7 behaves as compare. An operation that issues in cycle t pulses `wb_valid` in cycle t+L.
- R3: If a source register has a result still pending, the operation holds until the cycle in which that result writes back, and it issues in that cycle. Negate, absolute value and square root read only `dec_src1`. All other classes also read `dec_src2`.
- R4: An operation that writes a register holds while its destination still has a pending result.
- R5: The repeat intervals are add 3, multiply 4, divide 35, square root 111, negate 1, absolute value 1 and compare 2. An operation holds until that many cycles have passed since the last issue of its own class.
- R6: An operation holds if its write-back cycle t+L is already reserved by an earlier operation.
- R7: When `dec_wr` is 0, or the class is compare, the operation skips the destination check and leaves no pending result. A class that reads one source ignores `dec_src2` entirely.
- R8: A cycle with `flush` high issues nothing. It clears all pending results, class intervals and reservations from the next cycle on.
- R9: `issue` is high only with `dec_valid`, and `stall` equals `dec_valid` and not `issue`.
- R10: Operations of different classes can issue in consecutive cycles, and they write back in latency order rather than in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of all tracking state |
| dec_valid | input | 1 | An operation is present at decode |
| dec_op | input | 3 | Operation class code |
| dec_wr | input | 1 | Operation writes its destination register |
| dec_dst | input | RW | Destination register |
| dec_src1 | input | RW | First source register |
| dec_src2 | input | RW | Second source register |
| issue | output | 1 | Operation leaves decode this cycle |
| stall | output | 1 | Operation is held at decode this cycle |
| wb_valid | output | 1 | A result uses the write-back port this cycle |

## Verification
The embedded properties check on every cycle that `issue` never appears without a valid operation, and that `stall` is its complement. They also check that a multiply cannot repeat on the very next cycle, that a reader or rewriter of a register just written is held for at least one cycle, that an add followed by a compare never both issue into the same write-back cycle, and that flush silences the port. The exact hold length for each hazard can only be shown by the bench's scenarios, because it depends on the latency and interval tables. The same holds for the out-of-order write-back timing, the source and destination fields that are ignored, and the state cleared by flush. The scoreboard predicts each of these from the requirements.

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock #(
  parameter int NREG   = 32,
  parameter int MAXLAT = 112,
  parameter int RW     = $clog2(NREG),
  parameter int CW     = $clog2(MAXLAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          dec_valid,
  input  logic [2:0]    dec_op,
  input  logic          dec_wr,
  input  logic [RW-1:0] dec_dst,
  input  logic [RW-1:0] dec_src1,
  input  logic [RW-1:0] dec_src2,
  output logic          issue,
  output logic          stall,
  output logic          wb_valid
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_MUL = 3'd1, OP_DIV = 3'd2, OP_SQRT = 3'd3,
                         OP_NEG = 3'd4, OP_ABS = 3'd5, OP_CMP = 3'd6;
  localparam int NCLS = 7;

  function automatic logic [CW-1:0] lat_of(input logic [2:0] op);
    case (op)
      OP_ADD:  return CW'(4);
      OP_MUL:  return CW'(8);
      OP_DIV:  return CW'(36);
      OP_SQRT: return CW'(112);
      OP_NEG, OP_ABS: return CW'(2);
      default: return CW'(3);
    endcase
  endfunction

  function automatic logic [CW-1:0] ii_of(input logic [2:0] op);
    case (op)
      OP_ADD:  return CW'(3);
      OP_MUL:  return CW'(4);
      OP_DIV:  return CW'(35);
      OP_SQRT: return CW'(111);
      OP_NEG, OP_ABS: return CW'(1);
      default: return CW'(2);
    endcase
  endfunction

  logic [CW-1:0]   pend [NREG];
  logic [CW-1:0]   busy [NCLS];
  logic [MAXLAT:0] wbres;

  logic [CW-1:0] lat, ii;
  logic [2:0]    cls;
  logic          one_src, writes, raw, waw, unit_busy, port_busy;

  assign lat       = lat_of(dec_op);
  assign ii        = ii_of(dec_op);
  assign cls       = (dec_op == 3'd7) ? OP_CMP : dec_op;
  assign one_src   = (dec_op == OP_NEG) || (dec_op == OP_ABS) || (dec_op == OP_SQRT);
  assign writes    = dec_wr && (cls != OP_CMP);
  assign raw       = (pend[dec_src1] != '0) || (!one_src && pend[dec_src2] != '0);
  assign waw       = writes && (pend[dec_dst] != '0);
  assign unit_busy = busy[cls] != '0;
  assign port_busy = wbres[lat];

  assign issue    = dec_valid && !flush && !(raw || waw || unit_busy || port_busy);
  assign stall    = dec_valid && !issue;
  assign wb_valid = wbres[0];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n || flush)                                 pend[r] <= '0;
      else if (issue && writes && dec_dst == RW'(r))       pend[r] <= lat - CW'(1);
      else if (pend[r] != '0)                              pend[r] <= pend[r] - CW'(1);
    end
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    always_ff @(posedge clk) begin
      if (!rst_n || flush)                                 busy[c] <= '0;
      else if (issue && cls == 3'(c))                      busy[c] <= ii - CW'(1);
      else if (busy[c] != '0)                              busy[c] <= busy[c] - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) wbres <= '0;
    else wbres <= (wbres >> 1) |
                  (issue ? ((MAXLAT+1)'(1) << (lat - CW'(1))) : '0);
  end

  // R9
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (dec_valid && !stall));

  // R5
  mul_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_op == OP_MUL) |=> !(issue && dec_op == OP_MUL));

  // R6
  wb_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_op == OP_ADD) |=> !(issue && dec_op == OP_CMP));

  // R3
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && writes) |=> !(issue && dec_src1 == $past(dec_dst)));

  // R4
  waw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && writes) |=> !(issue && dec_wr && dec_op != OP_CMP && dec_op != 3'd7
                            && dec_dst == $past(dec_dst)));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !wb_valid);
endmodule

// File: tb/fp_issue_interlock_tb.sv
module fp_issue_interlock_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, flush = 0, dec_valid = 0, dec_wr = 0;
  logic [2:0] dec_op = 0;
  logic [4:0] dec_dst = 0, dec_src1 = 0, dec_src2 = 0;
  logic issue, stall, wb_valid;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];

  fp_issue_interlock u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lat(input int op);
    case (op)
      0: return 4;  1: return 8;  2: return 36;  3: return 112;
      4, 5: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // monitor: scoreboard of expected write-back cycles (R2, R10)
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      int idx;
      idx = -1;
      foreach (exp_q[i]) if (exp_q[i] == cyc && idx < 0) idx = i;
      if (idx >= 0 || wb_valid) check(wb_valid == (idx >= 0), "R2 wb_valid", wb_valid, idx >= 0);
      if (idx >= 0) exp_q.delete(idx);
    end
  end

  task automatic send(input int op, input bit wr, input int d, s1, s2,
                      input int exp_stall, input string req);
    int stalls;
    stalls = 0;
    dec_valid = 1; dec_op = 3'(op); dec_wr = wr;
    dec_dst = 5'(d); dec_src1 = 5'(s1); dec_src2 = 5'(s2);
    forever begin
      #(CLK_PERIOD/4);
      check(stall == !issue, "R9 stall", stall, !issue);
      if (issue) begin
        exp_q.push_back(cyc + lat(op));
        @(negedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
      if (stalls > 300) break;
    end
    dec_valid = 0;
    check(stalls == exp_stall, req, stalls, exp_stall);
  endtask

  task automatic idle(input int n);
    dec_valid = 0;
    for (int i = 0; i < n; i++) begin
      #(CLK_PERIOD/4);
      if (i == 0) check(!issue && !stall, "R9 idle", issue, 0);
      @(negedge clk);
    end
  endtask

  task automatic do_flush();
    int keep[$];
    dec_valid = 0; flush = 1;
    foreach (exp_q[i]) if (exp_q[i] <= cyc) keep.push_back(exp_q[i]);
    exp_q = keep;
    @(negedge clk);
    flush = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    // R1
    check(!issue && !stall && !wb_valid, "R1 reset outputs", {issue, stall, wb_valid}, 0);
    @(negedge clk);
    // R1, R10, R6: add, then multiply, then negate blocked by add's write-back slot
    send(0, 1, 1, 2, 3, 0, "R1 first issue");
    send(1, 1, 4, 5, 6, 0, "R10 mixed classes back to back");
    send(4, 1, 7, 8, 9, 1, "R6 write-back slot taken");
    idle(20);
    // R3 via src1, then via src2
    send(1, 1, 10, 1, 2, 0, "R3 producer");
    send(0, 1, 11, 10, 3, 7, "R3 src1 waits for multiply");
    send(6, 0, 0, 0, 11, 3, "R3 src2 waits for add");
    idle(20);
    // R4
    send(2, 1, 12, 1, 2, 0, "R4 producer");
    send(0, 1, 12, 1, 2, 35, "R4 destination pending");
    idle(50);
    // R7
    send(1, 1, 13, 1, 2, 0, "R7 producer");
    send(4, 1, 14, 20, 13, 0, "R7 one-source ignores src2");
    send(0, 0, 15, 1, 2, 0, "R7 no-write skips dest check");
    send(4, 1, 16, 15, 0, 0, "R7 no-write leaves nothing pending");
    send(6, 1, 13, 3, 4, 0, "R7 compare skips dest check");
    idle(20);
    // R5 with R6 on top
    send(1, 1, 17, 1, 2, 0, "R5 first multiply");
    send(1, 1, 18, 1, 2, 3, "R5 multiply interval");
    send(0, 1, 19, 1, 2, 0, "R5 first add");
    send(0, 1, 20, 1, 2, 3, "R5 add interval plus R6 slot");
    idle(20);
    send(3, 1, 21, 1, 2, 0, "R5 first square root");
    send(3, 1, 22, 3, 4, 110, "R5 square root interval");
    idle(230);
    // R8
    send(1, 1, 23, 1, 2, 0, "R8 producer");
    do_flush();
    send(0, 1, 24, 23, 2, 0, "R8 pending cleared");
    send(1, 1, 25, 1, 2, 0, "R8 interval cleared");
    idle(20);
    check(exp_q.size() == 0, "R2 all write-backs seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule